// File: doc/BRIEF.md
# Packed Lane Add/Subtract with Lane-Flag Byte Select

This block treats two 32-bit operands as four independent byte lanes or two independent halfword lanes. It adds or subtracts lane by lane, signed or unsigned, and registers the packed result. Each lane's outcome also yields a greater-or-equal flag. These flags are kept in a 4-bit register with one bit per byte position. A halfword outcome is written to both bits of the bytes it covers.

A separate select operation reads the stored flags. It builds a 32-bit word byte by byte, taking each byte from the first operand or from the second. A typical use is an arithmetic step that compares lanes, followed by a select that keeps, for example, the larger lane values. All outputs are registered, so a result appears on the clock edge after the request.

Top module: `simd_ge_alu`

## Requirements
- R1: On reset (rst_ni low) result_o, sel_o and ge_o all become zero.
- R2: In byte mode (op_i[1]=0), each 8-bit lane of result_o is the lane sum or difference modulo 2^8. No carry or borrow crosses a lane boundary. result_o updates on the clock edge after valid_i with sel_en_i=0.
- R3: In halfword mode (op_i[1]=1), each 16-bit lane of result_o is the lane sum or difference modulo 2^16, with no carry or borrow between lanes.
- R4: Opcode encoding: op_i[0]=1 selects subtract (a_i minus b_i) and 0 selects add. op_i[1]=1 selects halfword lanes and 0 selects byte lanes. op_i[2]=1 selects signed and 0 selects unsigned.
- R5: For unsigned byte addition, a lane's flag is 1 exactly when the lane sum is at least 256.
- R6: For unsigned halfword addition, a lane's flag pair is 1 exactly when the lane sum is at least 65536.
- R7: For unsigned subtraction of either width, a lane's flag or flags are 1 exactly when the lane's a is at least its b.
- R8: For signed addition or subtraction, a lane's flag or flags are 1 exactly when the exact signed result is zero or positive.
- R9: Flag position: ge_o[3] belongs to bits 31:24 and ge_o[0] to bits 7:0. In halfword mode ge_o[3:2] carry the upper halfword flag and ge_o[1:0] carry the lower one, as equal pairs.
- R10: A select (valid_i=1, sel_en_i=1) loads sel_o on the next edge. Byte k of sel_o is byte k of a_i when the stored ge_o[k] is 1, and byte k of b_i when it is 0.
- R11: ge_o and result_o hold during a select and while valid_i is low. sel_o holds whenever no select is requested. op_i is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| sel_en_i | input | 1 | 1: select request, 0: arithmetic request |
| op_i | input | 3 | {signed, halfword, subtract} |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Registered packed arithmetic result |
| ge_o | output | 4 | Stored lane flags |
| sel_o | output | 32 | Registered select result |

## Verification
A wrong flag bit stays in the flag register. It shows at ge_o one cycle after the arithmetic request. It shows again in sel_o after the next select, where a byte comes from the wrong operand. A carry leaking across a lane shows as an off-by-one in the next lane of result_o on that same edge. A missing hold shows as ge_o or result_o changing one edge after an idle or select cycle.

// File: rtl/simd_ge_pkg.sv
package simd_ge_pkg;
  localparam int unsigned OP_W = 3;

  typedef struct packed {
    logic is_signed;
    logic is_half;
    logic is_sub;
  } op_t;
endpackage

// File: rtl/simd_lane_arith.sv
module simd_lane_arith #(
  parameter int unsigned LANE_W = 8
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic              sub_i,
  input  logic              signed_i,
  output logic [LANE_W-1:0] res_o,
  output logic              ge_o
);
  logic [LANE_W:0] a_ext, b_ext, full;

  always_comb begin
    a_ext = {signed_i & a_i[LANE_W-1], a_i};
    b_ext = {signed_i & b_i[LANE_W-1], b_i};
    full  = sub_i ? (a_ext - b_ext) : (a_ext + b_ext);
    res_o = full[LANE_W-1:0];
    // unsigned add: carry out; all other cases: exact result non-negative
    ge_o  = (!signed_i && !sub_i) ? full[LANE_W] : ~full[LANE_W];
  end
endmodule

// File: rtl/simd_lane_array.sv
module simd_lane_array #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [DATA_W-1:0]        a_i,
  input  logic [DATA_W-1:0]        b_i,
  input  simd_ge_pkg::op_t         op_i,
  output logic [DATA_W-1:0]        res_o,
  output logic [DATA_W/BYTE_W-1:0] ge_o
);
  localparam int unsigned N_BYTES = DATA_W / BYTE_W;
  localparam int unsigned HALF_W  = 2 * BYTE_W;
  localparam int unsigned N_HALF  = DATA_W / HALF_W;

  logic [DATA_W-1:0]  byte_res, half_res;
  logic [N_BYTES-1:0] byte_ge;
  logic [N_HALF-1:0]  half_ge;

  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    simd_lane_arith #(.LANE_W(BYTE_W)) u_lane (
      .a_i     (a_i[i*BYTE_W +: BYTE_W]),
      .b_i     (b_i[i*BYTE_W +: BYTE_W]),
      .sub_i   (op_i.is_sub),
      .signed_i(op_i.is_signed),
      .res_o   (byte_res[i*BYTE_W +: BYTE_W]),
      .ge_o    (byte_ge[i])
    );
  end

  for (genvar j = 0; j < N_HALF; j++) begin : g_half
    simd_lane_arith #(.LANE_W(HALF_W)) u_lane (
      .a_i     (a_i[j*HALF_W +: HALF_W]),
      .b_i     (b_i[j*HALF_W +: HALF_W]),
      .sub_i   (op_i.is_sub),
      .signed_i(op_i.is_signed),
      .res_o   (half_res[j*HALF_W +: HALF_W]),
      .ge_o    (half_ge[j])
    );
  end

  // halfword flag spread over both byte positions it covers
  for (genvar k = 0; k < N_BYTES; k++) begin : g_ge
    assign ge_o[k] = op_i.is_half ? half_ge[k/2] : byte_ge[k];
  end

  assign res_o = op_i.is_half ? half_res : byte_res;
endmodule

// File: rtl/simd_byte_select.sv
module simd_byte_select #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [DATA_W-1:0]        a_i,
  input  logic [DATA_W-1:0]        b_i,
  input  logic [DATA_W/BYTE_W-1:0] pick_a_i,
  output logic [DATA_W-1:0]        sel_o
);
  localparam int unsigned N_BYTES = DATA_W / BYTE_W;

  for (genvar k = 0; k < N_BYTES; k++) begin : g_mux
    assign sel_o[k*BYTE_W +: BYTE_W] = pick_a_i[k] ? a_i[k*BYTE_W +: BYTE_W]
                                                   : b_i[k*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/simd_ge_alu.sv
module simd_ge_alu #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                valid_i,
  input  logic                                sel_en_i,
  input  logic [simd_ge_pkg::OP_W-1:0]        op_i,
  input  logic [DATA_W-1:0]                   a_i,
  input  logic [DATA_W-1:0]                   b_i,
  output logic [DATA_W-1:0]                   result_o,
  output logic [DATA_W/BYTE_W-1:0]            ge_o,
  output logic [DATA_W-1:0]                   sel_o
);
  import simd_ge_pkg::*;

  localparam int unsigned N_BYTES = DATA_W / BYTE_W;

  op_t                op;
  logic [DATA_W-1:0]  arith_res, pick_res;
  logic [N_BYTES-1:0] arith_ge;
  logic [DATA_W-1:0]  result_q, sel_q;
  logic [N_BYTES-1:0] ge_q;
  logic               do_arith, do_sel;

  assign op       = op_t'(op_i);
  assign do_arith = valid_i & ~sel_en_i;
  assign do_sel   = valid_i &  sel_en_i;

  simd_lane_array #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_lanes (
    .a_i  (a_i),
    .b_i  (b_i),
    .op_i (op),
    .res_o(arith_res),
    .ge_o (arith_ge)
  );

  simd_byte_select #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_select (
    .a_i     (a_i),
    .b_i     (b_i),
    .pick_a_i(ge_q),
    .sel_o   (pick_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      ge_q     <= '0;
      sel_q    <= '0;
    end else begin
      if (do_arith) begin
        result_q <= arith_res;
        ge_q     <= arith_ge;
      end
      if (do_sel) sel_q <= pick_res;
    end
  end

  assign result_o = result_q;
  assign ge_o     = ge_q;
  assign sel_o    = sel_q;
endmodule

// File: rtl/simd_ge_alu_chk.sv
module simd_ge_alu_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic        sel_en_i,
  input logic [2:0]  op_i,
  input logic [31:0] a_i,
  input logic [31:0] b_i,
  input logic [31:0] result_o,
  input logic [3:0]  ge_o,
  input logic [31:0] sel_o
);
  function automatic logic [31:0] pick(input logic [31:0] a, input logic [31:0] b,
                                       input logic [3:0] g);
    logic [31:0] r;
    for (int k = 0; k < 4; k++) r[k*8 +: 8] = g[k] ? a[k*8 +: 8] : b[k*8 +: 8];
    return r;
  endfunction

  AST_GE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || sel_en_i) |=> $stable(ge_o)); // R11

  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i || sel_en_i) |=> $stable(result_o)); // R11

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && sel_en_i) |=> $stable(sel_o)); // R11

  AST_HALF_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sel_en_i && op_i[1]) |=> (ge_o[3] == ge_o[2] && ge_o[1] == ge_o[0])); // R9

  AST_SEL_PICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sel_en_i) |=> sel_o == pick($past(a_i), $past(b_i), $past(ge_o))); // R10

  AST_UBYTE_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sel_en_i && op_i == 3'b000) |=>
      ({ge_o[0], result_o[7:0]} == ($past({1'b0, a_i[7:0]}) + $past({1'b0, b_i[7:0]})))); // R5
endmodule

bind simd_ge_alu simd_ge_alu_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .sel_en_i(sel_en_i),
  .op_i    (op_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .result_o(result_o),
  .ge_o    (ge_o),
  .sel_o   (sel_o)
);

// File: tb/simd_ge_alu_test.sv
`timescale 1ns/1ps
module simd_ge_alu_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        sel_en_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [31:0] result_o, sel_o;
  logic [3:0]  ge_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  simd_ge_alu uut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .sel_en_i(sel_en_i),
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .result_o(result_o),
    .ge_o    (ge_o),
    .sel_o   (sel_o)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic [3:0]  ge;
  } vec_t;

  // op = {signed, half, sub}
  localparam vec_t TBL [8] = '{
    '{3'b000, 32'h80FF0110, 32'h80010F20, 32'h00001030, 4'b1100}, // R2 R5: no carry across lanes
    '{3'b001, 32'h10052000, 32'h10062001, 32'h00FF00FF, 4'b1010}, // R7 byte
    '{3'b010, 32'hFFFF1234, 32'h00011111, 32'h00002345, 4'b1100}, // R3 R6
    '{3'b011, 32'h12340005, 32'h12350005, 32'hFFFF0000, 4'b0011}, // R7 half
    '{3'b100, 32'h7F80FF01, 32'h0180FFFF, 32'h8000FE00, 4'b1001}, // R8 signed byte add
    '{3'b101, 32'h80007F05, 32'h0101FF05, 32'h7FFF8000, 4'b0011}, // R8 signed byte sub
    '{3'b110, 32'h80007FFF, 32'hFFFF0001, 32'h7FFF8000, 4'b0011}, // R8 R9 signed half add
    '{3'b111, 32'h00058000, 32'h00010001, 32'h00047FFF, 4'b1100}  // R8 R9 signed half sub
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic sel, input logic [2:0] op,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    valid_i = 1'b1; sel_en_i = sel; op_i = op; a_i = a; b_i = b;
    @(negedge clk);
    valid_i = 1'b0; sel_en_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 result", result_o, 32'h0);
    check("R1 ge", {28'h0, ge_o}, 32'h0);
    check("R1 sel", sel_o, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < 8; i++) begin
      issue(1'b0, TBL[i].op, TBL[i].a, TBL[i].b);
      check("R2/R3/R4 result", result_o, TBL[i].res);
      check("R5-R9 ge", {28'h0, ge_o}, {28'h0, TBL[i].ge});
    end

    // select with stored ge = 1100
    issue(1'b1, 3'b000, 32'h11223344, 32'hAABBCCDD);
    check("R10 select", sel_o, 32'h1122CCDD);
    check("R11 ge held on select", {28'h0, ge_o}, 32'hC);
    check("R11 result held on select", result_o, 32'h00047FFF);

    // idle with changing op and operands
    @(negedge clk);
    op_i = 3'b001; a_i = 32'h0; b_i = 32'hFFFFFFFF;
    @(negedge clk);
    @(negedge clk);
    check("R11 idle result", result_o, 32'h00047FFF);
    check("R11 idle ge", {28'h0, ge_o}, 32'hC);
    check("R11 idle sel", sel_o, 32'h1122CCDD);

    // reset mid-run
    rst_ni = 1'b0;
    #1;
    check("R1 result after reset", result_o, 32'h0);
    check("R1 ge after reset", {28'h0, ge_o}, 32'h0);
    check("R1 sel after reset", sel_o, 32'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    // ge = 0000: every byte from b
    issue(1'b1, 3'b000, 32'h11223344, 32'hAABBCCDD);
    check("R10 select all b", sel_o, 32'hAABBCCDD);

    // unsigned byte sub, equal lanes -> all ones, then select all a
    issue(1'b0, 3'b001, 32'h01020304, 32'h01020304);
    check("R7 equal lanes ge", {28'h0, ge_o}, 32'hF);
    check("R2 zero diff", result_o, 32'h0);
    issue(1'b1, 3'b000, 32'h11223344, 32'hAABBCCDD);
    check("R10 select all a", sel_o, 32'h11223344);

    // arithmetic and select bits together: select wins, ge held
    issue(1'b1, 3'b000, 32'hFFFFFFFF, 32'hFFFFFFFF);
    check("R11 ge held with op present", {28'h0, ge_o}, 32'hF);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule